// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer and Event Counter

This block is an up-counter with a reload value, reached through a byte-wide register port. Software selects one of three ways of advancing it. The first counts chosen edges of an external input. The second counts instruction-clock enable pulses. The third is an armed, one-shot measurement of how long the external input stays at a chosen level. When the count passes its all-ones value, the counter takes the reload value again and issues a wake-up pulse. It also issues an interrupt-request pulse, but only while the interrupt-enable input is high.

Multi-byte values move atomically through a shared low-byte holding buffer. To set the reload value, software writes the low byte first and then the high byte; the high-byte write commits both bytes together. To read the counter, software reads the high byte first, which also captures the low byte into the buffer; the low byte read afterwards is therefore the one taken at the same moment. The external input passes through a synchronizer before its edges are detected. The instruction-clock enable is supplied from outside and is expected to be one system clock in four.

Top module: `mm_timer16`

## Requirements
- R1: After reset the counter, the reload value, the low buffer and the control register are all zero, so the control address (0x11) and both count bytes read 0x00.
- R2: A write to the low address (0x10) changes only the low buffer. A following write to the high address (0x0F) commits {written byte, buffer} as the reload value. If the counter is stopped (run bit 4 clear), that write also loads the counter.
- R3: A read of the high address returns counter bits 15:8 and copies counter bits 7:0 into the low buffer. A read of the low address returns the buffer, so it gives the captured byte even if the counter has moved since, or the byte last written there. Read data appears one clock after the read strobe.
- R4: While the run bit is set, a high-address write changes only the reload value and leaves the count untouched.
- R5: Mode 01 (control bits 7:6) counts edges of the synchronized input: rising edges when the edge bit (control bit 3) is 1, falling edges when it is 0. The opposite edge has no effect. With the run bit clear the count holds.
- R6: Mode 10 adds one per cycle in which the instruction-clock enable is high while the run bit is set.
- R7: In a counting cycle at 0xFFFF, the counter loads the reload value in place of wrapping. In the same clock edge it raises a one-cycle interrupt-request pulse and a one-cycle wake-up pulse.
- R8: When the interrupt-enable input is low, an overflow raises no interrupt request, but the wake-up pulse still occurs.
- R9: Mode 11 with the run bit set waits for the active edge of the input (rising if the edge bit is 1, falling if 0). It then counts instruction-clock enables while the input stays at the new level. When the input returns, counting stops and the run bit clears by itself.
- R10: In mode 11 the result is held after a measurement, and edges are ignored until software sets the run bit again. The next measurement then continues from the held value.
- R11: An overflow during a mode-11 measurement reloads the counter and raises the interrupt request, as in the other modes.
- R12: The control register reads back mode, run and edge bits at their positions, with all other bits zero. Mode 00 never counts, even with the run bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| ext_in | input | 1 | External event/measurement input (asynchronous) |
| icyc_en | input | 1 | Instruction-clock enable |
| irq_en | input | 1 | Interrupt enable |
| irq_req | output | 1 | One-cycle interrupt request on overflow |
| wake | output | 1 | One-cycle wake-up pulse on overflow |

## Verification
The bench builds the block with its default parameters: a 16-bit count, 8-bit register bytes, the three register addresses above and a two-stage synchronizer. Because the count width is 16, wrap-around can be reached in a few instruction-clock pulses once software loads a value near 0xFFFF. This makes overflow reachable in every counting mode, including overflow in the middle of a pulse-width measurement. The two-stage synchronizer fixes the delay from an input change to the edge detector at three clocks, so the bench waits a known time after each input change before it drives enable pulses.

// File: rtl/mm_timer16_pkg.sv
package mm_timer16_pkg;

   typedef enum logic [1:0] {
      MD_IDLE  = 2'b00,
      MD_EVENT = 2'b01,
      MD_TIMER = 2'b10,
      MD_PULSE = 2'b11
   } tmr_mode_e;

   typedef struct packed {
      tmr_mode_e mode;
      logic      run;
      logic      rise_sel;
   } tmr_ctl_t;

   localparam int CTL_MODE_LSB = 6;
   localparam int CTL_RUN_BIT  = 4;
   localparam int CTL_EDGE_BIT = 3;
   localparam int CTL_MIN_W    = 8;

endpackage

// File: rtl/mm_pin_sync.sv
module mm_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic lvl_o,
   output logic rise_o,
   output logic fall_o
);

   initial begin : chk_params
      assert (STAGES >= 2) else $fatal(1, "mm_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= 1'b0;
               else        chain_q[gi] <= pin_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= 1'b0;
               else        chain_q[gi] <= chain_q[gi-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign lvl_o  = chain_q[STAGES-1];
   assign rise_o = chain_q[STAGES-1] & ~prev_q;
   assign fall_o = ~chain_q[STAGES-1] & prev_q;

endmodule

// File: rtl/mm_timer_regs.sv
module mm_timer_regs
   import mm_timer16_pkg::*;
#(
   parameter int              DATA_W   = 8,
   parameter int              CNT_W    = 16,
   parameter int              ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] ADDR_HI  = 8'h0F,
   parameter logic [ADDR_W-1:0] ADDR_LO  = 8'h10,
   parameter logic [ADDR_W-1:0] ADDR_CTL = 8'h11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              wr_i,
   input  logic              rd_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              pw_done_i,
   output tmr_ctl_t          ctl_o,
   output logic [CNT_W-1:0]  preload_o,
   output logic              ld_o,
   output logic [CNT_W-1:0]  ld_val_o
);

   localparam int HI_W = CNT_W - DATA_W;

   initial begin : chk_params
      assert (CNT_W == 2 * DATA_W) else $fatal(1, "mm_timer_regs: CNT_W must be twice DATA_W");
      assert (DATA_W >= CTL_MIN_W) else $fatal(1, "mm_timer_regs: DATA_W too narrow for control fields");
   end

   logic [DATA_W-1:0] lowbuf_q;
   logic [CNT_W-1:0]  preload_q;
   tmr_ctl_t          ctl_q;
   logic [DATA_W-1:0] rdata_q;
   logic [DATA_W-1:0] ctl_byte;

   logic wr_hi, wr_lo, wr_ctl, rd_hi, rd_lo, rd_ctl;

   assign wr_hi  = wr_i && (addr_i == ADDR_HI);
   assign wr_lo  = wr_i && (addr_i == ADDR_LO);
   assign wr_ctl = wr_i && (addr_i == ADDR_CTL);
   assign rd_hi  = rd_i && (addr_i == ADDR_HI);
   assign rd_lo  = rd_i && (addr_i == ADDR_LO);
   assign rd_ctl = rd_i && (addr_i == ADDR_CTL);

   always_comb begin
      ctl_byte = '0;
      ctl_byte[CTL_MODE_LSB +: 2] = ctl_q.mode;
      ctl_byte[CTL_RUN_BIT]       = ctl_q.run;
      ctl_byte[CTL_EDGE_BIT]      = ctl_q.rise_sel;
   end

   assign ld_val_o = {wdata_i[HI_W-1:0], lowbuf_q};
   assign ld_o     = wr_hi && !ctl_q.run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lowbuf_q  <= '0;
         preload_q <= '0;
         ctl_q     <= '0;
         rdata_q   <= '0;
      end else begin
         if (rd_hi) begin
            rdata_q  <= cnt_i[CNT_W-1:DATA_W];
            lowbuf_q <= cnt_i[DATA_W-1:0];
         end
         if (rd_lo)  rdata_q <= lowbuf_q;
         if (rd_ctl) rdata_q <= ctl_byte;
         if (wr_lo)  lowbuf_q <= wdata_i;
         if (wr_hi)  preload_q <= ld_val_o;
         if (wr_ctl) begin
            ctl_q.mode     <= tmr_mode_e'(wdata_i[CTL_MODE_LSB +: 2]);
            ctl_q.run      <= wdata_i[CTL_RUN_BIT];
            ctl_q.rise_sel <= wdata_i[CTL_EDGE_BIT];
         end else if (pw_done_i) begin
            ctl_q.run <= 1'b0;
         end
      end
   end

   assign ctl_o     = ctl_q;
   assign preload_o = preload_q;
   assign rdata_o   = rdata_q;

   AST_LOWBUF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> (preload_q == $past(preload_q))); // R2

endmodule

// File: rtl/mm_timer_core.sv
module mm_timer_core
   import mm_timer16_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  tmr_ctl_t         ctl_i,
   input  logic [CNT_W-1:0] preload_i,
   input  logic             ld_i,
   input  logic [CNT_W-1:0] ld_val_i,
   input  logic             icyc_i,
   input  logic             lvl_i,
   input  logic             rise_i,
   input  logic             fall_i,
   input  logic             irq_en_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             pw_done_o,
   output logic             irq_o,
   output logic             wake_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;
   logic             meas_q, meas_n;
   logic             irq_q, wake_q;
   logic             step;
   logic             act_edge;
   logic             wrap;

   assign act_edge = ctl_i.rise_sel ? rise_i : fall_i;

   always_comb begin
      step      = 1'b0;
      meas_n    = meas_q;
      pw_done_o = 1'b0;
      if (!ctl_i.run) begin
         meas_n = 1'b0;
      end else begin
         unique case (ctl_i.mode)
            MD_EVENT: step = act_edge;
            MD_TIMER: step = icyc_i;
            MD_PULSE: begin
               if (!meas_q) begin
                  meas_n = act_edge;
               end else if (lvl_i != ctl_i.rise_sel) begin
                  meas_n    = 1'b0;
                  pw_done_o = 1'b1;
               end else begin
                  step = icyc_i;
               end
            end
            default: meas_n = 1'b0;
         endcase
      end
   end

   assign wrap = step && (cnt_q == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         meas_q <= 1'b0;
         irq_q  <= 1'b0;
         wake_q <= 1'b0;
      end else begin
         meas_q <= meas_n;
         irq_q  <= wrap && irq_en_i;
         wake_q <= wrap;
         if (ld_i)       cnt_q <= ld_val_i;
         else if (wrap)  cnt_q <= preload_i;
         else if (step)  cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o  = cnt_q;
   assign irq_o  = irq_q;
   assign wake_o = wake_q;

   AST_RELOAD_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      wake_q |-> (cnt_q == $past(preload_i))); // R7

   AST_IRQ_NEEDS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> wake_q); // R8

   AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_i.run && !ld_i) |=> (cnt_q == $past(cnt_q))); // R5

   AST_IDLE_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_i.mode == MD_IDLE && !ld_i) |=> (cnt_q == $past(cnt_q))); // R12

endmodule

// File: rtl/mm_timer16.sv
module mm_timer16
   import mm_timer16_pkg::*;
#(
   parameter int                DATA_W      = 8,
   parameter int                CNT_W       = 16,
   parameter int                ADDR_W      = 8,
   parameter int                SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] ADDR_HI     = 8'h0F,
   parameter logic [ADDR_W-1:0] ADDR_LO     = 8'h10,
   parameter logic [ADDR_W-1:0] ADDR_CTL    = 8'h11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_wr,
   input  logic              reg_rd,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              ext_in,
   input  logic              icyc_en,
   input  logic              irq_en,
   output logic              irq_req,
   output logic              wake
);

   initial begin : chk_params
      assert (ADDR_HI != ADDR_LO && ADDR_LO != ADDR_CTL && ADDR_HI != ADDR_CTL)
         else $fatal(1, "mm_timer16: register addresses must differ");
   end

   tmr_ctl_t         ctl;
   logic [CNT_W-1:0] preload, ld_val, cnt;
   logic             ld, pw_done;
   logic             pin_lvl, pin_rise, pin_fall;

   mm_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (ext_in),
      .lvl_o  (pin_lvl),
      .rise_o (pin_rise),
      .fall_o (pin_fall)
   );

   mm_timer_regs #(
      .DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
      .ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO), .ADDR_CTL(ADDR_CTL)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_i    (reg_addr),
      .wdata_i   (reg_wdata),
      .wr_i      (reg_wr),
      .rd_i      (reg_rd),
      .rdata_o   (reg_rdata),
      .cnt_i     (cnt),
      .pw_done_i (pw_done),
      .ctl_o     (ctl),
      .preload_o (preload),
      .ld_o      (ld),
      .ld_val_o  (ld_val)
   );

   mm_timer_core #(.CNT_W(CNT_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_i     (ctl),
      .preload_i (preload),
      .ld_i      (ld),
      .ld_val_i  (ld_val),
      .icyc_i    (icyc_en),
      .lvl_i     (pin_lvl),
      .rise_i    (pin_rise),
      .fall_i    (pin_fall),
      .irq_en_i  (irq_en),
      .cnt_o     (cnt),
      .pw_done_o (pw_done),
      .irq_o     (irq_req),
      .wake_o    (wake)
   );

   logic ctl_wr;
   assign ctl_wr = reg_wr && (reg_addr == ADDR_CTL);

   AST_PW_AUTOCLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      pw_done |=> (!ctl.run || $past(ctl_wr))); // R9

   AST_RUN_WRITE_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_HI && ctl.run && ctl.mode == MD_IDLE) |=> $stable(cnt)); // R4

endmodule

// File: tb/mm_timer16_test.sv
module mm_timer16_test;

   localparam logic [7:0] A_HI = 8'h0F, A_LO = 8'h10, A_CTL = 8'h11;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] reg_addr = '0, reg_wdata = '0, reg_rdata;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic       ext_in = 1'b0, icyc_en = 1'b0, irq_en = 1'b1;
   logic       irq_req, wake;

   int errors = 0, checks = 0;
   int irqs = 0, wakes = 0;
   bit done = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic       rd_q = 1'b0;

   always #2 clk = ~clk;

   mm_timer16 uut (
      .clk(clk), .rst_n(rst_n),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_rdata(reg_rdata), .ext_in(ext_in), .icyc_en(icyc_en), .irq_en(irq_en),
      .irq_req(irq_req), .wake(wake)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard whenever read data becomes valid
   always @(posedge clk) rd_q <= reg_rd;
   always @(negedge clk) begin
      if (rd_q) begin
         if (exp_q.size() == 0) begin
            check("scoreboard underflow", 1, 0);
         end else begin
            check(tag_q.pop_front(), int'(reg_rdata), int'(exp_q.pop_front()));
         end
      end
   end

   always @(posedge clk) begin
      if (rst_n) begin
         if (irq_req) irqs++;
         if (wake)    wakes++;
      end
   end

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic rd16(input logic [15:0] e, input string tag);
      rd(A_HI, e[15:8], tag);
      rd(A_LO, e[7:0], tag);
   endtask

   task automatic pin(input logic v);
      @(negedge clk);
      ext_in = v;
      repeat (6) @(negedge clk);
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); icyc_en = 1'b1;
         @(negedge clk); icyc_en = 1'b0;
         @(negedge clk);
         @(negedge clk);
      end
   endtask

   initial begin : watchdog
      #400000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stim
      int i0, w0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(A_CTL, 8'h00, "R1 control after reset");
      rd16(16'h0000, "R1 count after reset");

      // R2 low write alone leaves count, high write commits and loads
      wr(A_LO, 8'h77);
      rd(A_HI, 8'h00, "R2 count high after low write");
      wr(A_LO, 8'h34);
      wr(A_HI, 8'h12);
      rd16(16'h1234, "R2 stopped load");

      // R3 buffer readback and snapshot
      wr(A_LO, 8'h99);
      rd(A_LO, 8'h99, "R3 buffer holds written byte");
      wr(A_CTL, 8'h58);
      rd(A_CTL, 8'h58, "R12 control readback");
      rd(A_HI, 8'h12, "R3 high read");
      pin(1'b1); pin(1'b0);
      rd(A_LO, 8'h34, "R3 low byte from snapshot");
      rd16(16'h1235, "R5 rising edge counted once");
      pin(1'b1); pin(1'b0);

      // R4 running write changes only the reload value
      wr(A_LO, 8'hF0);
      wr(A_HI, 8'hFF);
      rd16(16'h1236, "R4 count unchanged by running write");

      // R5 falling-edge select, then run bit clear
      wr(A_CTL, 8'h50);
      pin(1'b1);
      rd16(16'h1236, "R5 rising ignored on falling select");
      pin(1'b0);
      rd16(16'h1237, "R5 falling counted");
      wr(A_CTL, 8'h40);
      pin(1'b1); pin(1'b0);
      rd16(16'h1237, "R5 held with run clear");

      // R6/R7 timer mode and overflow
      wr(A_LO, 8'hFE); wr(A_HI, 8'hFF);
      wr(A_CTL, 8'h90);
      wr(A_LO, 8'h00); wr(A_HI, 8'h10);
      i0 = irqs; w0 = wakes;
      tick(1);
      check("R7 no request before wrap", irqs - i0, 0);
      tick(1);
      repeat (2) @(negedge clk);
      check("R7 one request on wrap", irqs - i0, 1);
      check("R7 one wake on wrap", wakes - w0, 1);
      tick(3);
      rd16(16'h1003, "R6 R7 reload then timer counts");

      // R8 interrupt enable low
      wr(A_CTL, 8'h80);
      wr(A_LO, 8'hFF); wr(A_HI, 8'hFF);
      wr(A_CTL, 8'h90);
      irq_en = 1'b0;
      i0 = irqs; w0 = wakes;
      tick(1);
      repeat (2) @(negedge clk);
      check("R8 request blocked", irqs - i0, 0);
      check("R8 wake still pulses", wakes - w0, 1);
      rd16(16'hFFFF, "R8 reload value taken");
      irq_en = 1'b1;

      // R9 pulse width, rising
      wr(A_CTL, 8'h00);
      wr(A_LO, 8'h00); wr(A_HI, 8'h00);
      wr(A_CTL, 8'hD8);
      tick(3);
      pin(1'b1);
      tick(5);
      pin(1'b0);
      rd(A_CTL, 8'hC8, "R9 run bit cleared itself");
      rd16(16'h0005, "R9 measured width");

      // R10 held result, re-arm on falling edge
      pin(1'b1); tick(2); pin(1'b0);
      rd16(16'h0005, "R10 result held after edges");
      wr(A_CTL, 8'hD0);
      tick(2);
      pin(1'b1);
      tick(2);
      rd16(16'h0005, "R10 waits for falling edge");
      pin(1'b0);
      tick(4);
      pin(1'b1);
      rd16(16'h0009, "R10 second measurement adds on");
      rd(A_CTL, 8'hC0, "R10 run cleared again");

      // R11 overflow while measuring
      pin(1'b0);
      wr(A_LO, 8'hFE); wr(A_HI, 8'hFF);
      wr(A_CTL, 8'hD8);
      i0 = irqs;
      pin(1'b1);
      tick(3);
      pin(1'b0);
      check("R11 request during measurement", irqs - i0, 1);
      rd16(16'hFFFF, "R11 reload then continued");

      // R12 mode 00 never counts
      wr(A_CTL, 8'h00);
      wr(A_LO, 8'h55); wr(A_HI, 8'h00);
      wr(A_CTL, 8'h18);
      tick(3);
      pin(1'b1); pin(1'b0);
      rd16(16'h0055, "R12 idle mode holds");
      rd(A_CTL, 8'h18, "R12 idle control readback");

      repeat (4) @(negedge clk);
      check("scoreboard drained", exp_q.size(), 0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule